// File: doc/BRIEF.md
# Register-Buffer Control-Word Write Sequencer

This block sits in a memory host controller and turns one request into the bus pattern that programs a single 4-bit control word inside a registering clock buffer. A request carries a 4-bit word index and 4-bit data over a valid/ready handshake. When a request is accepted, the sequencer drives one command cycle. In that cycle chip selects 0 and 1 go low together, and the index and data go onto fixed address and bank bit positions. On the following clock it presents the even/odd parity of that command. It then keeps every chip select high for a settle period before it accepts the next request.

The settle period is not fixed. For most writes it is a short count (8 clocks by default). A write that changes a clock-timing bit of a word uses a long stabilisation count instead. To tell whether such a bit changed, the sequencer keeps a shadow copy of the last value it wrote to each of the 16 words. One word controls a power-down feature. When that word is written with its enable bit set, the sequencer makes sure at least one clock-enable output stays high for the whole command-and-settle window.

Top module: `cw_prog_seq`

## Requirements
- R1: After reset, reqReady=1, busy=0, every csN bit=1, rasN=casN=weN=1, addrOut=0, bankOut=0, parOut=1, and ckeOut equals ckeIn.
- R2: A request is accepted on a rising edge where reqValid and reqReady are both 1. In the next cycle only, csN[0] and csN[1] are both 0; any higher chip selects stay 1. While no request is accepted, all chip selects stay 1.
- R3: In the command cycle, addrOut[2:0]=reqIndex[2:0], bankOut[2]=reqIndex[3], addrOut[3]=reqData[0], addrOut[4]=reqData[1], bankOut[0]=reqData[2], bankOut[1]=reqData[3], and addrOut bits 5 and up are 0. Outside the command cycle, addrOut and bankOut are 0.
- R4: rasN, casN and weN are 1 in every cycle, including the command cycle.
- R5: In every cycle after reset, parOut equals the XOR of all bits of addrOut, bankOut, rasN, casN and weN from the previous cycle.
- R6: After a write that does not qualify for R7, reqReady is 0 (and busy 1) in the command cycle and in the MRD_CYCLES cycles after it, with all chip selects 1. reqReady returns to 1 in the next cycle.
- R7: The wait becomes STAB_CYCLES in place of MRD_CYCLES when the written data differs, under a mask, from the last value written to that word (0 after reset). The masks are: word 2, reqData[3]; word 6, reqData[1]; words 10 and 11, reqData[1:0].
- R8: Rewriting word 2, 6, 10 or 11 with the masked bits unchanged uses the MRD_CYCLES wait, whatever the other bits are.
- R9: A write to word 9 with reqData[3]=1 forces ckeOut[0]=1 from the command cycle to the end of its wait, when ckeIn is all zero. In every other case ckeOut equals ckeIn.
- R10: busy is always the inverse of reqReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request present |
| reqReady | output | 1 | Sequencer can take a request |
| reqIndex | input | 4 | Control word number |
| reqData | input | 4 | Value to program |
| ckeIn | input | NUM_CKE | Clock enables requested by the controller |
| busy | output | 1 | Write or settle period in progress |
| csN | output | NUM_CS | Active-low chip selects |
| addrOut | output | ADDR_W | Address bus |
| bankOut | output | 3 | Bank address bus |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| parOut | output | 1 | Parity of the previous cycle's address and command bits |
| ckeOut | output | NUM_CKE | Clock enables sent to the buffer |

## Verification
The hardest case to reach is the choice of wait length. That choice depends on the history of each word, not on the current request alone. A request that looks the same can take either wait, depending on what was written to that word earlier. The stimulus writes every data value to every word in ascending data order, so each timing word sees masked bits that change as well as masked bits that repeat. The bench keeps its own per-word history and predicts the wait count for every write.

// File: rtl/cw_prog_pkg.sv
package cw_prog_pkg;
  localparam int IDX_W = 4;
  localparam int DATA_W = 4;
  localparam int BANK_W = 3;
  localparam int NUM_WORDS = 1 << IDX_W;
  localparam logic [IDX_W-1:0] GUARD_IDX = 4'd9;
  localparam int GUARD_BIT = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_WAIT} seqState_t;

  typedef struct packed {
    logic take;   // latch the request
    logic issue;  // command cycle on the bus
    logic hold;   // command or settle window
  } seqStrobe_t;

  // data bits of a word that affect clock timing
  function automatic logic [DATA_W-1:0] timingBits(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd2:         timingBits = 4'b1000;
      4'd6:         timingBits = 4'b0010;
      4'd10, 4'd11: timingBits = 4'b0011;
      default:      timingBits = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/cw_prog_ctl.sv
module cw_prog_ctl
  import cw_prog_pkg::*;
#(
  parameter int MRD_CYCLES = 8,
  parameter int STAB_CYCLES = 4800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       longWait,
  output logic       reqReady,
  output logic       busy,
  output seqStrobe_t strobe
);
  localparam int LONGEST = (STAB_CYCLES > MRD_CYCLES) ? STAB_CYCLES : MRD_CYCLES;
  localparam int CNT_W = $clog2(LONGEST + 1);

  seqState_t stateQ;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (reqValid) stateQ <= ST_CMD;
        ST_CMD: begin
          cntQ <= longWait ? CNT_W'(STAB_CYCLES - 1) : CNT_W'(MRD_CYCLES - 1);
          stateQ <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cntQ == '0) stateQ <= ST_IDLE;
          else cntQ <= cntQ - 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady = (stateQ == ST_IDLE);
    busy = (stateQ != ST_IDLE);
    strobe.take = reqValid && (stateQ == ST_IDLE);
    strobe.issue = (stateQ == ST_CMD);
    strobe.hold = (stateQ != ST_IDLE);
  end
endmodule

// File: rtl/cw_prog_dp.sv
module cw_prog_dp
  import cw_prog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CS = 2,
  parameter int NUM_CKE = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [IDX_W-1:0]   reqIndex,
  input  logic [DATA_W-1:0]  reqData,
  input  logic [NUM_CKE-1:0] ckeIn,
  output logic               longWait,
  output logic [NUM_CS-1:0]  csN,
  output logic [ADDR_W-1:0]  addrOut,
  output logic [BANK_W-1:0]  bankOut,
  output logic               rasN,
  output logic               casN,
  output logic               weN,
  output logic               parOut,
  output logic [NUM_CKE-1:0] ckeOut
);
  logic [IDX_W-1:0] idxQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] shadowQ [NUM_WORDS];
  logic guard;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      dataQ <= '0;
    end else if (strobe.take) begin
      idxQ <= reqIndex;
      dataQ <= reqData;
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (!rstN) shadowQ[w] <= '0;
      else if (strobe.issue && idxQ == IDX_W'(w)) shadowQ[w] <= dataQ;
    end
  end

  assign longWait = |((dataQ ^ shadowQ[idxQ]) & timingBits(idxQ));
  assign guard = (idxQ == GUARD_IDX) && dataQ[GUARD_BIT];

  always_comb begin
    addrOut = '0;
    bankOut = '0;
    if (strobe.issue) begin
      addrOut[2:0] = idxQ[2:0];
      addrOut[3] = dataQ[0];
      addrOut[4] = dataQ[1];
      bankOut = {idxQ[3], dataQ[3], dataQ[2]};
    end
  end

  assign rasN = 1'b1;
  assign casN = 1'b1;
  assign weN = 1'b1;

  for (genvar i = 0; i < NUM_CS; i++) begin : gCs
    if (i < 2) begin : gPair
      assign csN[i] = !strobe.issue;
    end else begin : gIdle
      assign csN[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) parOut <= 1'b1;
    else parOut <= ^{addrOut, bankOut, rasN, casN, weN};
  end

  always_comb begin
    ckeOut = ckeIn;
    if (strobe.hold && guard && ckeIn == '0) ckeOut[0] = 1'b1;
  end
endmodule

// File: rtl/cw_prog_seq.sv
module cw_prog_seq
  import cw_prog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CS = 2,
  parameter int NUM_CKE = 2,
  parameter int MRD_CYCLES = 8,
  parameter int STAB_CYCLES = 4800
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [3:0]         reqIndex,
  input  logic [3:0]         reqData,
  input  logic [NUM_CKE-1:0] ckeIn,
  output logic               busy,
  output logic [NUM_CS-1:0]  csN,
  output logic [ADDR_W-1:0]  addrOut,
  output logic [2:0]         bankOut,
  output logic               rasN,
  output logic               casN,
  output logic               weN,
  output logic               parOut,
  output logic [NUM_CKE-1:0] ckeOut
);
  seqStrobe_t strobe;
  logic longWait;

  cw_prog_ctl #(.MRD_CYCLES(MRD_CYCLES), .STAB_CYCLES(STAB_CYCLES)) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .longWait(longWait),
    .reqReady(reqReady), .busy(busy), .strobe(strobe)
  );

  cw_prog_dp #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .NUM_CKE(NUM_CKE)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqIndex(reqIndex),
    .reqData(reqData), .ckeIn(ckeIn), .longWait(longWait), .csN(csN),
    .addrOut(addrOut), .bankOut(bankOut), .rasN(rasN), .casN(casN),
    .weN(weN), .parOut(parOut), .ckeOut(ckeOut)
  );
endmodule

// File: rtl/cw_prog_chk.sv
module cw_prog_chk #(
  parameter int ADDR_W = 16,
  parameter int NUM_CS = 2,
  parameter int NUM_CKE = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               busy,
  input logic [NUM_CS-1:0]  csN,
  input logic [ADDR_W-1:0]  addrOut,
  input logic [2:0]         bankOut,
  input logic               rasN,
  input logic               casN,
  input logic               weN,
  input logic               parOut,
  input logic [NUM_CKE-1:0] ckeOut
);
  // R2
  accept_to_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!csN[0] && !csN[1]));
  // R2
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN[0] |=> csN[0]);
  // R3
  upper_addr_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN[0] |-> (addrOut >> 5) == '0);
  // R4
  cmd_lines_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    rasN && casN && weN);
  // R5
  late_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    parOut == ^$past({addrOut, bankOut, rasN, casN, weN}));
  // R6
  cmd_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN[0] |-> (!reqReady && busy));
  // R9
  cke_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN[0] && addrOut[2:0] == 3'b001 && bankOut[2] && bankOut[1]) |-> |ckeOut);
  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy != reqReady);
endmodule

bind cw_prog_seq cw_prog_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .NUM_CKE(NUM_CKE)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .busy(busy),
  .csN(csN), .addrOut(addrOut), .bankOut(bankOut), .rasN(rasN), .casN(casN),
  .weN(weN), .parOut(parOut), .ckeOut(ckeOut)
);

// File: tb/tb_cw_prog_seq.sv
module tb_cw_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MRD = 8;
  localparam int STAB = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady, busy, rasN, casN, weN, parOut;
  logic [3:0] reqIndex = '0, reqData = '0;
  logic [1:0] ckeIn = '0, ckeOut, csN;
  logic [15:0] addrOut;
  logic [2:0] bankOut;

  int checks = 0;
  int fails = 0;
  logic [3:0] shadow [16];

  cw_prog_seq #(.MRD_CYCLES(MRD), .STAB_CYCLES(STAB)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIndex(reqIndex), .reqData(reqData), .ckeIn(ckeIn), .busy(busy),
    .csN(csN), .addrOut(addrOut), .bankOut(bankOut), .rasN(rasN),
    .casN(casN), .weN(weN), .parOut(parOut), .ckeOut(ckeOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] maskOf(input logic [3:0] idx);
    if (idx == 4'd2) return 4'b1000;
    if (idx == 4'd6) return 4'b0010;
    if (idx == 4'd10 || idx == 4'd11) return 4'b0011;
    return 4'b0000;
  endfunction

  task automatic doWrite(input logic [3:0] idx, input logic [3:0] d, input logic [1:0] cke);
    logic isLong, guard;
    logic [1:0] ckeExp;
    logic [15:0] addrExp;
    logic [2:0] bankExp;
    int waitExp, cnt;
    string wtag;
    isLong = |((d ^ shadow[idx]) & maskOf(idx));
    guard = (idx == 4'd9) && d[3];
    ckeExp = (guard && cke == 2'b00) ? 2'b01 : cke;
    waitExp = isLong ? STAB : MRD;
    wtag = isLong ? "R7" : ((maskOf(idx) != 0) ? "R8" : "R6");
    addrExp = {11'b0, d[1], d[0], idx[2:0]};
    bankExp = {idx[3], d[3], d[2]};
    shadow[idx] = d;
    @(negedge clk);
    reqValid = 1'b1; reqIndex = idx; reqData = d; ckeIn = cke;
    #1;
    chk("R2 ready when idle", reqReady, 1);
    chk("R2 cs idle", csN, 2'b11);
    chk("R9 cke passthrough idle", ckeOut, cke);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 cmd cs low", csN, 2'b00);
    chk("R3 addr placement", addrOut, addrExp);
    chk("R3 bank placement", bankOut, bankExp);
    chk("R4 ras cas we high", {rasN, casN, weN}, 3'b111);
    chk("R5 parity of idle", parOut, 1);
    chk("R10 busy in cmd", {busy, reqReady}, 2'b10);
    chk("R9 cke in cmd", ckeOut, ckeExp);
    @(negedge clk);
    chk("R5 parity of cmd", parOut, ^{addrExp[4:0], bankExp, 3'b111});
    cnt = 0;
    while (busy && cnt < STAB + 4) begin
      chk("R6 cs high in wait", csN, 2'b11);
      chk("R3 bus idle in wait", {addrOut, bankOut}, 0);
      chk("R9 cke in wait", ckeOut, ckeExp);
      chk("R10 busy vs ready", reqReady, 0);
      cnt++;
      @(negedge clk);
    end
    chk({wtag, " wait length"}, cnt, waitExp);
    chk("R10 ready after wait", {busy, reqReady}, 2'b01);
  endtask

  initial begin
    for (int w = 0; w < 16; w++) shadow[w] = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready", reqReady, 1);
    chk("R1 busy", busy, 0);
    chk("R1 cs", csN, 2'b11);
    chk("R1 cmd lines", {rasN, casN, weN}, 3'b111);
    chk("R1 bus", {addrOut, bankOut}, 0);
    chk("R1 parity", parOut, 1);
    chk("R1 cke", ckeOut, ckeIn);
    rstN = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R2 no request no cs", csN, 2'b11);
      chk("R5 idle parity", parOut, 1);
    end
    for (int d = 0; d < 16; d++)
      for (int i = 0; i < 16; i++)
        doWrite(4'(i), 4'(d), 2'((i ^ d) & 3));
    // targeted: word 9 guard with both cke low, then timing rewrite pairs
    doWrite(4'd9, 4'b1000, 2'b00);
    doWrite(4'd9, 4'b0111, 2'b00);
    doWrite(4'd2, 4'b0111, 2'b10);
    doWrite(4'd2, 4'b1111, 2'b10);
    doWrite(4'd10, 4'b1101, 2'b01);
    doWrite(4'd10, 4'b0001, 2'b01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule